// File: doc/BRIEF.md
# Multi-channel interprocessor mailbox

This block lets several processors on one chip pass short messages to each other through a set of one-way channels. Each channel has its own register window. A sender claims a free channel by writing its one-hot identity bit into the channel's owner register and reading the value back to confirm the claim. It then loads the message words, chooses a one-hot destination line and an acknowledge mode, and writes its identity bit into the send register. That write raises the destination's interrupt line. Every write carries a sideband processor index, and the owner and send registers check it against the written bit.

A global key register gates every channel write. Until the correct key is written, only the key register responds to writes. Each channel reports whether it is idle and whether its message has been acknowledged. The acknowledge comes either automatically one cycle after the send, or when the receiver clears its interrupt. The owner then releases the channel, which makes it idle again.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset, all interrupt lines are low, the key register at 0xA00 reads 1 (locked), every channel's mode/status register reads 0x10, its owner register reads 0 and its mask register reads 0xFFFFFFFF.
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the block, and that register then reads 0. Writing any other value to it locks the block again, and it then reads 1.
- R3: While the block is locked, writes to channel registers change nothing. Owner, mask and interrupt state read back unchanged.
- R4: Channel c occupies byte addresses c*0x40 to c*0x40+0x3F; its owner register is at offset 0x00. On an unowned idle channel, a write to the owner register of a value equal to 1<<id, where id is the sideband index, sets the owner to that bit, and reading back returns it.
- R5: A write to the owner register is ignored if another owner is held, or if the written value differs from 1<<id.
- R6: Eight 32-bit message words sit at offsets 0x20, 0x24 up to 0x3C and read back what was written.
- R7: Writing the owner's bit with a matching id to the send register (0x1C) of an idle channel makes it busy and sets its pending lines to the destination (0x04). Interrupt line k is high while some channel has k pending and bit k of that channel's mask (0x14, 1 = masked) is 0. Sends by anyone but the owner are ignored. Offset 0x18 reads the pending bits.
- R8: Mode/status (0x10) reads bit0 = automatic-acknowledge mode, bit4 = idle and bit7 = acknowledged. When bit0 is written 1, the acknowledged state follows one cycle after the busy state begins.
- R9: With bit0 = 0, the channel stays busy until a write to 0x18 clears one of its pending bits. That write drops those lines and sets acknowledged.
- R10: A write of the owner's bit with a matching id to 0x00, while the channel is busy or acknowledged, clears the owner and the pending bits and returns the channel to idle.
- R11: A write to 0x08 clears the written bits from the destination. Offsets 0x04 and 0x0C both read the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| wr_id | input | 5 | Index of the processor issuing the write |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 32 | One interrupt line per processor |

## Verification
The bench builds the block with its default parameters: 32 channels, 32 interrupt lines and eight message words. This puts the highest window at 0x7C0 within reach, so the test can drive line 31 from channel 31 and check that the key register above the windows never aliases a channel. A single channel is taken through a full interrupt-mode exchange. Automatic acknowledge is checked on the top channel, where the busy and acknowledged reads are one cycle apart. Masking, clearing the destination and writes made while locked are checked on other channels.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic [1:0] {CH_IDLE, CH_BUSY, CH_ACKED} ch_state_e;

    // Word slots inside a 0x40-byte channel window
    localparam logic [3:0] SLOT_OWNER = 4'd0;
    localparam logic [3:0] SLOT_DST   = 4'd1;
    localparam logic [3:0] SLOT_DCLR  = 4'd2;
    localparam logic [3:0] SLOT_DSTAT = 4'd3;
    localparam logic [3:0] SLOT_MODE  = 4'd4;
    localparam logic [3:0] SLOT_MASK  = 4'd5;
    localparam logic [3:0] SLOT_ICLR  = 4'd6;
    localparam logic [3:0] SLOT_SEND  = 4'd7;

    localparam logic [31:0] OPEN_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/mbox_lock.sv
module mbox_lock
    import mbox_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic          unlocked_o
);
    typedef struct packed {
        logic locked;
    } lock_regs_t;

    lock_regs_t d, q;

    always_comb begin
        d = q;
        if (we_i) d.locked = (wdata_i != DW'(OPEN_KEY));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{locked: 1'b1};
        else        q <= d;
    end

    assign unlocked_o = ~q.locked;

    a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i == DW'(OPEN_KEY)) |=> unlocked_o);
    a_r2_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i != DW'(OPEN_KEY)) |=> !unlocked_o);
    a_r2_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(unlocked_o));
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
    import mbox_pkg::*;
#(
    parameter int NUM_IRQ   = 32,
    parameter int NUM_WORDS = 8,
    parameter int DW        = 32,
    localparam int ID_W     = $clog2(NUM_IRQ),
    localparam int WIDX_W   = $clog2(NUM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [3:0]         slot_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic [ID_W-1:0]    wr_id_i,
    output logic [DW-1:0]      rdata_o,
    output logic [NUM_IRQ-1:0] irq_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0]                owner;
        logic [NUM_IRQ-1:0]                dst;
        logic [NUM_IRQ-1:0]                mask;
        logic [NUM_IRQ-1:0]                pend;
        logic                              auto_ack;
        ch_state_e                         st;
        logic [NUM_WORDS-1:0][DW-1:0]      words;
    } chan_regs_t;

    chan_regs_t d, q;
    logic [NUM_IRQ-1:0] wbits;
    logic [NUM_IRQ-1:0] id_bit;
    logic               is_me;

    always_comb begin
        d      = q;
        wbits  = wdata_i[NUM_IRQ-1:0];
        id_bit = '0;
        id_bit[wr_id_i] = 1'b1;
        is_me  = (wbits == id_bit);

        // automatic acknowledge lands one cycle after the send
        if (q.st == CH_BUSY && q.auto_ack) d.st = CH_ACKED;

        if (we_i) begin
            case (slot_i)
                SLOT_OWNER: begin
                    if (q.owner == '0) begin
                        if (q.st == CH_IDLE && is_me) d.owner = id_bit;
                    end else if (is_me && wbits == q.owner && q.st != CH_IDLE) begin
                        d.owner = '0;
                        d.pend  = '0;
                        d.st    = CH_IDLE;
                    end
                end
                SLOT_DST:  d.dst      = wbits;
                SLOT_DCLR: d.dst      = q.dst & ~wbits;
                SLOT_MODE: d.auto_ack = wdata_i[0];
                SLOT_MASK: d.mask     = wbits;
                SLOT_ICLR: begin
                    if ((wbits & q.pend) != '0) begin
                        d.pend = q.pend & ~wbits;
                        if (q.st == CH_BUSY && !q.auto_ack) d.st = CH_ACKED;
                    end
                end
                SLOT_SEND: begin
                    if (q.st == CH_IDLE && q.owner != '0 && is_me && wbits == q.owner) begin
                        d.st   = CH_BUSY;
                        d.pend = q.pend | q.dst;
                    end
                end
                default: begin
                    if (slot_i[3]) d.words[slot_i[WIDX_W-1:0]] = wdata_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{owner: '0, dst: '0, mask: '1, pend: '0,
                           auto_ack: 1'b0, st: CH_IDLE, words: '0};
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        case (slot_i)
            SLOT_OWNER:          rdata_o[NUM_IRQ-1:0] = q.owner;
            SLOT_DST, SLOT_DSTAT: rdata_o[NUM_IRQ-1:0] = q.dst;
            SLOT_MASK:           rdata_o[NUM_IRQ-1:0] = q.mask;
            SLOT_ICLR:           rdata_o[NUM_IRQ-1:0] = q.pend;
            SLOT_MODE: begin
                rdata_o[0] = q.auto_ack;
                rdata_o[4] = (q.st == CH_IDLE);
                rdata_o[7] = (q.st == CH_ACKED);
            end
            SLOT_DCLR, SLOT_SEND: rdata_o = '0;
            default: if (slot_i[3]) rdata_o = q.words[slot_i[WIDX_W-1:0]];
        endcase
    end

    assign irq_o = q.pend & ~q.mask;

    a_r4_owner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.owner));
    a_r10_unowned_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q.owner == '0) |-> (q.st == CH_IDLE));
    a_r8_auto_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CH_BUSY && q.auto_ack) |=> (q.st != CH_BUSY));
    a_r7_busy_needs_send: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CH_IDLE && !(we_i && slot_i == SLOT_SEND)) |=> (q.st == CH_IDLE));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int              NUM_CH    = 32,
    parameter int              NUM_IRQ   = 32,
    parameter int              NUM_WORDS = 8,
    parameter int              DW        = 32,
    parameter int              AW        = 12,
    parameter logic [AW-1:0]   LOCK_ADDR = 12'hA00,
    localparam int             ID_W      = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    input  logic [ID_W-1:0]    wr_id,
    output logic [DW-1:0]      rdata,
    output logic [NUM_IRQ-1:0] irq
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int WIN_W = AW - 6;

    logic               unlocked;
    logic               aligned;
    logic               lock_hit;
    logic               ch_hit;
    logic [WIN_W-1:0]   win;
    logic [CH_W-1:0]    ch_sel;
    logic [DW-1:0]      ch_rd  [NUM_CH];
    logic [NUM_IRQ-1:0] ch_irq [NUM_CH];

    assign aligned  = (addr[1:0] == 2'b00);
    assign win      = addr[AW-1:6];
    assign ch_sel   = addr[6 +: CH_W];
    assign ch_hit   = aligned && (win < WIN_W'(NUM_CH));
    assign lock_hit = (addr == LOCK_ADDR);

    mbox_lock #(.DW(DW)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (wr_en && lock_hit),
        .wdata_i    (wdata),
        .unlocked_o (unlocked)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        mbox_chan #(.NUM_IRQ(NUM_IRQ), .NUM_WORDS(NUM_WORDS), .DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (wr_en && unlocked && ch_hit && (ch_sel == CH_W'(c))),
            .slot_i  (addr[5:2]),
            .wdata_i (wdata),
            .wr_id_i (wr_id),
            .rdata_o (ch_rd[c]),
            .irq_o   (ch_irq[c])
        );
    end

    always_comb begin
        irq = '0;
        for (int c = 0; c < NUM_CH; c++) irq = irq | ch_irq[c];
    end

    always_comb begin
        rdata = '0;
        if (lock_hit)    rdata[0] = ~unlocked;
        else if (ch_hit) rdata = ch_rd[ch_sel];
    end

    a_r3_locked_irq_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(irq));
endmodule

// File: tb/mbox_ctrl_tb.sv
module mbox_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [4:0]  wr_id = '0;
    logic [31:0] rdata;
    logic [31:0] irq;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    mbox_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .wr_id(wr_id), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic        is_wr;
        logic [11:0] a;
        logic [31:0] v;     // write data or expected read data
        logic [4:0]  id;
        logic [31:0] exp_irq;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 49;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 12'hA00, 32'h1ACCE551, 5'd0, 32'h0, 4'd2},   // R2 unlock
        '{1'b0, 12'hA00, 32'h0,        5'd0, 32'h0, 4'd2},   // R2 reads 0
        '{1'b1, 12'h000, 32'h4,        5'd2, 32'h0, 4'd4},   // R4 claim ch0
        '{1'b0, 12'h000, 32'h4,        5'd0, 32'h0, 4'd4},   // R4 readback
        '{1'b1, 12'h000, 32'h8,        5'd3, 32'h0, 4'd5},   // R5 rival claim
        '{1'b0, 12'h000, 32'h4,        5'd0, 32'h0, 4'd5},   // R5 unchanged
        '{1'b1, 12'h020, 32'hCAFE0001, 5'd2, 32'h0, 4'd6},   // R6
        '{1'b1, 12'h03C, 32'h12345678, 5'd2, 32'h0, 4'd6},
        '{1'b0, 12'h020, 32'hCAFE0001, 5'd0, 32'h0, 4'd6},   // R6
        '{1'b0, 12'h03C, 32'h12345678, 5'd0, 32'h0, 4'd6},   // R6
        '{1'b1, 12'h004, 32'h20,       5'd2, 32'h0, 4'd7},
        '{1'b1, 12'h014, 32'hFFFFFFDF, 5'd2, 32'h0, 4'd7},
        '{1'b1, 12'h010, 32'h0,        5'd2, 32'h0, 4'd9},
        '{1'b0, 12'h010, 32'h10,       5'd0, 32'h0, 4'd9},   // R9 idle, irq mode
        '{1'b1, 12'h01C, 32'h4,        5'd2, 32'h0, 4'd7},   // R7 send
        '{1'b0, 12'h010, 32'h0,        5'd0, 32'h20, 4'd7},  // R7 busy, line 5
        '{1'b0, 12'h010, 32'h0,        5'd0, 32'h20, 4'd9},  // R9 no ack yet
        '{1'b1, 12'h018, 32'h20,       5'd5, 32'h0, 4'd9},   // R9 receiver clears
        '{1'b0, 12'h010, 32'h80,       5'd0, 32'h0, 4'd9},   // R9 acked
        '{1'b1, 12'h000, 32'h4,        5'd2, 32'h0, 4'd10},  // R10 release
        '{1'b0, 12'h010, 32'h10,       5'd0, 32'h0, 4'd10},  // R10 idle
        '{1'b0, 12'h000, 32'h0,        5'd0, 32'h0, 4'd10},  // R10 no owner
        '{1'b1, 12'h7C0, 32'h80,       5'd7, 32'h0, 4'd8},
        '{1'b1, 12'h7C4, 32'h80000000, 5'd7, 32'h0, 4'd8},
        '{1'b1, 12'h7D4, 32'h7FFFFFFF, 5'd7, 32'h0, 4'd8},
        '{1'b1, 12'h7D0, 32'h1,        5'd7, 32'h0, 4'd8},
        '{1'b1, 12'h7DC, 32'h80,       5'd7, 32'h0, 4'd8},   // R8 send ch31
        '{1'b0, 12'h7D0, 32'h01,       5'd0, 32'h80000000, 4'd8}, // R8 busy
        '{1'b0, 12'h7D0, 32'h81,       5'd0, 32'h80000000, 4'd8}, // R8 acked
        '{1'b1, 12'h7C0, 32'h80,       5'd3, 32'h0, 4'd5},   // R5 id mismatch
        '{1'b0, 12'h7C0, 32'h80,       5'd0, 32'h80000000, 4'd5}, // R5
        '{1'b1, 12'h7C0, 32'h80,       5'd7, 32'h0, 4'd10},  // R10 release
        '{1'b0, 12'h7D0, 32'h11,       5'd0, 32'h0, 4'd10},  // R10
        '{1'b1, 12'h09C, 32'h1,        5'd0, 32'h0, 4'd7},   // R7 unowned send
        '{1'b0, 12'h090, 32'h10,       5'd0, 32'h0, 4'd7},   // R7 still idle
        '{1'b1, 12'h044, 32'h0F,       5'd0, 32'h0, 4'd11},  // R11
        '{1'b1, 12'h048, 32'h05,       5'd0, 32'h0, 4'd11},
        '{1'b0, 12'h04C, 32'h0A,       5'd0, 32'h0, 4'd11},  // R11 status
        '{1'b1, 12'h040, 32'h1,        5'd0, 32'h0, 4'd7},
        '{1'b1, 12'h05C, 32'h1,        5'd0, 32'h0, 4'd7},
        '{1'b0, 12'h050, 32'h0,        5'd0, 32'h0, 4'd7},   // R7 masked low
        '{1'b1, 12'h054, 32'hFFFFFFF7, 5'd0, 32'h0, 4'd7},
        '{1'b0, 12'h058, 32'h0A,       5'd0, 32'h08, 4'd7},  // R7 pending, line 3
        '{1'b1, 12'hA00, 32'h0,        5'd0, 32'h0, 4'd2},   // R2 relock
        '{1'b0, 12'hA00, 32'h1,        5'd0, 32'h08, 4'd2},  // R2 reads 1
        '{1'b1, 12'h080, 32'h1,        5'd0, 32'h0, 4'd3},   // R3 claim locked
        '{1'b0, 12'h080, 32'h0,        5'd0, 32'h08, 4'd3},  // R3
        '{1'b1, 12'h054, 32'hFFFFFFFF, 5'd0, 32'h0, 4'd3},   // R3 mask locked
        '{1'b0, 12'h054, 32'hFFFFFFF7, 5'd0, 32'h08, 4'd3}   // R3
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] v, input logic [4:0] id);
        @(negedge clk);
        addr = a; wdata = v; wr_id = id; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic do_rd(input int req, input logic [11:0] a,
                         input logic [31:0] exp, input logic [31:0] exp_irq);
        @(negedge clk);
        addr = a;
        #1;
        check(req, $sformatf("read %h", a), rdata, exp);
        check(req, $sformatf("irq at %h", a), irq, exp_irq);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        do_rd(1, 12'hA00, 32'h1, 32'h0);
        do_rd(1, 12'h010, 32'h10, 32'h0);
        do_rd(1, 12'h7D0, 32'h10, 32'h0);
        do_rd(1, 12'h014, 32'hFFFFFFFF, 32'h0);
        do_rd(1, 12'h000, 32'h0, 32'h0);

        for (int i = 0; i < NSTEP; i++) begin
            if (STEPS[i].is_wr) do_wr(STEPS[i].a, STEPS[i].v, STEPS[i].id);
            else do_rd(int'(STEPS[i].req), STEPS[i].a, STEPS[i].v, STEPS[i].exp_irq);
        end

        // R1: reset in the middle of traffic returns everything to its initial state
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        do_rd(1, 12'hA00, 32'h1, 32'h0);
        do_rd(1, 12'h054, 32'hFFFFFFFF, 32'h0);
        do_rd(1, 12'h040, 32'h0, 32'h0);

        // R3: a channel write issued before unlocking is lost
        do_wr(12'h000, 32'h2, 5'd1);
        do_wr(12'hA00, 32'h1ACCE551, 5'd0);
        do_rd(3, 12'h000, 32'h0, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule